// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block executes already-decoded command and data bytes for a pair of digital potentiometer channels, A and B. Each channel holds a volatile register, whose value is the 8-bit wiper code driven to the analog side, and a nonvolatile register that models persistent storage. The nonvolatile registers are not cleared by reset. They take their power-up contents from parameters and keep every later store across any number of resets.

A command arrives as a one-cycle strobe carrying a command byte and a data byte. The high nibble of the command byte picks the operation: write volatile, write nonvolatile, or copy between the two registers in either direction. The low nibble picks channel A, channel B or both. A write-protect input blocks every change to storage. While it is high, a volatile write reloads the stored value instead of taking the data byte. Each store to nonvolatile storage holds a busy flag for a programmable number of cycles, and commands that arrive during that time are discarded. On the first clock edge after reset is released, both volatile registers are refilled from storage.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: While `rst_n` is low, both wiper outputs are 00h and `store_busy` is 0.
- R2: On the first clock edge after `rst_n` rises, each wiper is loaded from its nonvolatile register. A strobe at that edge is discarded. Nonvolatile contents survive reset, and before the first store they hold `NV_INIT_A` and `NV_INIT_B`.
- R3: Operation nibble 1h (command bits 7:4) with write protect low loads the data byte into the selected wipers at the strobe edge and leaves storage unchanged. Every code from 00h to FFh is accepted.
- R4: Operation nibble 1h with write protect high ignores the data byte and copies each selected channel's nonvolatile value into its wiper.
- R5: Operation nibble 2h with write protect low writes the data byte into the selected nonvolatile registers and leaves the wipers unchanged.
- R6: Operation nibble 6h copies nonvolatile into the selected wipers, whatever the write-protect level.
- R7: Operation nibble 5h with write protect low copies each selected wiper into its nonvolatile register.
- R8: With write protect high, operation nibbles 2h and 5h change no register and do not raise `store_busy`.
- R9: Channel nibble 1h (command bits 3:0) selects A only, 2h selects B only, and 3h selects both. An unselected channel is left untouched.
- R10: A strobe whose operation nibble is not 1h, 2h, 5h or 6h, or whose channel nibble is not 1h, 2h or 3h, changes no register and does not raise `store_busy`.
- R11: An accepted store (R5 or R7) raises `store_busy` for exactly `STORE_CYCLES` cycles, starting after the strobe edge. Strobes that arrive while it is high are discarded.
- R12: Write protect passes through two synchronising flops. The level a strobe sees is the value `wp_in` had two clock edges before the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_byte | input | 8 | Operation nibble [7:4], channel nibble [3:0] |
| data_byte | input | 8 | Wiper code for write operations |
| wp_in | input | 1 | Asynchronous write-protect level |
| wiper_a | output | 8 | Volatile code of channel A |
| wiper_b | output | 8 | Volatile code of channel B |
| store_busy | output | 1 | High while a storage write is in progress |

## Verification
The hardest case to reach is a write-protect edge that arrives together with a command. The level a strobe sees lags the pin by two edges, so a strobe issued right after `wp_in` changes must still follow the old rule. The stimulus toggles `wp_in` in the same cycle as a volatile write, then repeats that write once the level has settled. Nonvolatile contents can only be seen through the wipers, so every store is followed by a copy into a wiper, including across a reset in the middle of the run. A cycle-accurate behavioural model in the bench predicts every cycle.

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl #(
  parameter int          STORE_CYCLES = 16,
  parameter logic [7:0]  NV_INIT_A    = 8'h5A,
  parameter logic [7:0]  NV_INIT_B    = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] data_byte,
  input  logic       wp_in,
  output logic [7:0] wiper_a,
  output logic [7:0] wiper_b,
  output logic       store_busy
);
  localparam int CW = $clog2(STORE_CYCLES + 1);
  localparam logic [3:0] OP_VWR  = 4'h1;
  localparam logic [3:0] OP_NWR  = 4'h2;
  localparam logic [3:0] OP_V2NV = 4'h5;
  localparam logic [3:0] OP_NV2V = 4'h6;

  logic [7:0]    vol_a, vol_b;
  logic [7:0]    nv_a = NV_INIT_A;
  logic [7:0]    nv_b = NV_INIT_B;
  logic          loading;
  logic [1:0]    wp_s;
  logic [CW-1:0] busy_cnt;

  wire [3:0] op     = cmd_byte[7:4];
  wire [3:0] ch     = cmd_byte[3:0];
  wire       sel_a  = (ch == 4'h1) || (ch == 4'h3);
  wire       sel_b  = (ch == 4'h2) || (ch == 4'h3);
  wire       wp_lvl = wp_s[1];
  wire       go     = cmd_valid && !loading && (busy_cnt == '0) && (sel_a || sel_b);

  wire do_vwr = go && (op == OP_VWR) && !wp_lvl;
  wire do_vld = go && ((op == OP_NV2V) || ((op == OP_VWR) && wp_lvl));
  wire do_nwr = go && (op == OP_NWR) && !wp_lvl;
  wire do_nst = go && (op == OP_V2NV) && !wp_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_s    <= 2'b00;
      loading <= 1'b1;
    end else begin
      wp_s    <= {wp_s[0], wp_in};
      loading <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_a <= '0;
      vol_b <= '0;
    end else if (loading) begin
      vol_a <= nv_a;
      vol_b <= nv_b;
    end else begin
      if (do_vwr && sel_a) vol_a <= data_byte;
      if (do_vld && sel_a) vol_a <= nv_a;
      if (do_vwr && sel_b) vol_b <= data_byte;
      if (do_vld && sel_b) vol_b <= nv_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (do_nwr && sel_a) nv_a <= data_byte;
      if (do_nst && sel_a) nv_a <= vol_a;
      if (do_nwr && sel_b) nv_b <= data_byte;
      if (do_nst && sel_b) nv_b <= vol_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (do_nwr || do_nst) busy_cnt <= CW'(STORE_CYCLES);
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end

  assign wiper_a    = vol_a;
  assign wiper_b    = vol_b;
  assign store_busy = (busy_cnt != '0);
endmodule

// File: rtl/dual_wiper_ctrl_chk.sv
module dual_wiper_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic [7:0] data_byte,
  input logic [7:0] wiper_a,
  input logic [7:0] wiper_b,
  input logic       store_busy,
  input logic       loading,
  input logic       wp_lvl
);
  wire [3:0] op    = cmd_byte[7:4];
  wire [3:0] ch    = cmd_byte[3:0];
  wire       ch_ok = (ch == 4'h1) || (ch == 4'h2) || (ch == 4'h3);
  wire       op_ok = (op == 4'h1) || (op == 4'h2) || (op == 4'h5) || (op == 4'h6);
  wire       acc   = cmd_valid && !store_busy && !loading;

  a_r11_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && store_busy) |=> ($stable(wiper_a) && $stable(wiper_b)));

  a_r5_store_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ch_ok && (op == 4'h2) && !wp_lvl) |=> (store_busy && $stable(wiper_a) && $stable(wiper_b)));

  a_r3_vwrite_a: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_byte == 8'h11) && !wp_lvl) |=> (wiper_a == $past(data_byte)));

  a_r8_protect_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ch_ok && ((op == 4'h2) || (op == 4'h5)) && wp_lvl) |=> !store_busy);

  a_r10_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(op_ok && ch_ok)) |=> ($stable(wiper_a) && $stable(wiper_b) && !store_busy));

  a_r9_b_only_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (ch == 4'h2)) |=> $stable(wiper_a));
endmodule

bind dual_wiper_ctrl dual_wiper_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .data_byte(data_byte), .wiper_a(wiper_a), .wiper_b(wiper_b),
  .store_busy(store_busy), .loading(loading), .wp_lvl(wp_lvl)
);

// File: tb/dual_wiper_ctrl_bench.sv
module dual_wiper_ctrl_bench;
  localparam int SC = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] data_byte = 8'h00;
  logic wp_in = 1'b0;
  logic [7:0] wiper_a, wiper_b;
  logic store_busy;

  always #4 clk = ~clk;

  dual_wiper_ctrl #(.STORE_CYCLES(SC), .NV_INIT_A(8'h5A), .NV_INIT_B(8'hA5)) u_dual_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_byte(data_byte), .wp_in(wp_in), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .store_busy(store_busy)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int ma = 0, mb = 0, nva = 8'h5A, nvb = 8'hA5, mcnt = 0, w1 = 0, w2 = 0;
  bit mload = 1'b1;

  task automatic check(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    int op, ch, wps, nxt;
    bit sa, sb, acc;
    @(posedge clk);
    if (!rst_n) begin
      ma = 0; mb = 0; mload = 1'b1; mcnt = 0; w1 = 0; w2 = 0;
    end else begin
      op  = int'(cmd_byte[7:4]);
      ch  = int'(cmd_byte[3:0]);
      wps = w2;
      sa  = (ch == 1) || (ch == 3);
      sb  = (ch == 2) || (ch == 3);
      acc = cmd_valid && !mload && (mcnt == 0) && (sa || sb);
      nxt = (mcnt > 0) ? mcnt - 1 : 0;
      if (mload) begin
        ma = nva; mb = nvb; mload = 1'b0;
      end else if (acc) begin
        case (op)
          1: if (wps == 0) begin
               if (sa) ma = int'(data_byte);
               if (sb) mb = int'(data_byte);
             end else begin
               if (sa) ma = nva;
               if (sb) mb = nvb;
             end
          6: begin
               if (sa) ma = nva;
               if (sb) mb = nvb;
             end
          2: if (wps == 0) begin
               if (sa) nva = int'(data_byte);
               if (sb) nvb = int'(data_byte);
               nxt = SC;
             end
          5: if (wps == 0) begin
               if (sa) nva = ma;
               if (sb) nvb = mb;
               nxt = SC;
             end
          default: ;
        endcase
      end
      mcnt = nxt;
      w2 = w1;
      w1 = int'(wp_in);
    end
    #2;
    check("wiper_a", int'(wiper_a), ma);
    check("wiper_b", int'(wiper_b), mb);
    check("store_busy", int'(store_busy), (mcnt != 0) ? 1 : 0);
  endtask

  task automatic cmd(input logic [7:0] c, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_byte = c; data_byte = d;
    tick();
    cmd_valid = 1'b0;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    cur_req = "R1"; idle(3);
    cur_req = "R2";
    rst_n = 1'b1; cmd_valid = 1'b1; cmd_byte = 8'h11; data_byte = 8'h99;
    tick(); cmd_valid = 1'b0; idle(2);
    cur_req = "R3"; cmd(8'h11, 8'h33); cmd(8'h12, 8'hC4);
    cur_req = "R9"; cmd(8'h13, 8'hFF); cmd(8'h13, 8'h00); cmd(8'h11, 8'h80);
    cur_req = "R5"; cmd(8'h21, 8'h77);
    cur_req = "R11"; cmd(8'h11, 8'h99); idle(SC);
    cur_req = "R6"; cmd(8'h61, 8'h00);
    cur_req = "R7"; cmd(8'h12, 8'h2C); cmd(8'h52, 8'h00); idle(SC);
    cmd(8'h12, 8'h01); cmd(8'h62, 8'h00);
    cur_req = "R10"; cmd(8'h31, 8'h44); cmd(8'h01, 8'h44); cmd(8'h10, 8'h44);
    cmd(8'h14, 8'h44); cmd(8'hF3, 8'h44); cmd(8'h20, 8'h44);
    cur_req = "R12"; wp_in = 1'b1; cmd(8'h11, 8'h12);
    cur_req = "R4"; idle(2); cmd(8'h13, 8'h34);
    cur_req = "R8"; cmd(8'h21, 8'h00); cmd(8'h53, 8'h00); cmd(8'h63, 8'h00);
    cur_req = "R6"; cmd(8'h12, 8'h00); cmd(8'h62, 8'h00);
    cur_req = "R12"; wp_in = 1'b0; cmd(8'h21, 8'h09); idle(SC);
    cmd(8'h61, 8'h00);
    cur_req = "R2"; cmd(8'h13, 8'h01);
    rst_n = 1'b0; cur_req = "R1"; idle(2);
    cur_req = "R2"; rst_n = 1'b1; idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule